// File: doc/BRIEF.md
# Matrix Keypad Scanner and Key Encoder

This block reads a 4x4 key matrix. It drives one row low at a time, walking through the four rows, and it reads the four active-low column lines back through a two-flop synchronizer. For each row it joins the row drive and the synchronized columns into one 8-bit pattern. That pattern is mapped to a 5-bit key code. Codes 0 to 9 are digit keys, codes 10, 11 and 12 are the add, subtract and multiply operators, and code 13 is equals. Code 31 (all ones) means that no single key is pressed.

The scan rate comes from a single-cycle enable that is divided down from the system clock. A divisor of about 8467 gives a step rate of roughly 4 kHz from a 33.8688 MHz clock. The results of one full sweep of the four rows are gathered together, and the registered key code is updated once at the end of each sweep. A sweep that shows no key, two columns low in one row, or hits in two rows gives the idle code. A downstream debouncer and calculator use the code.

Top module: `keypad_scanner`

## Requirements
- R1: After reset or clear, `row_n` is 0111. It advances every `STEP_DIV` clock cycles through 1110, 1101, 1011 and back to 0111. Exactly one row is low at any time, and `row_n` does not change between steps. The first step comes on the `STEP_DIV`-th rising edge after reset or clear is released.
- R2: `clr` is active high and synchronous. It restarts the step divider, returns the row counter to its first state (`row_n` = 0111), drops any partial sweep and sets `key_code` to 11111.
- R3: `rst_n` is active low and synchronous. It gives the same state as clear: `row_n` = 0111 and `key_code` = 11111.
- R4: A single pressed key at row r (the key pulls `col_n[c]` low while `row_n[r]` is low) and column c gives `key_code` = 4·r + c. For example, pattern {row_n, columns} 11101110 gives 0, 11011101 gives 5 and 01110111 gives 15.
- R5: With no key pressed, `key_code` is 11111.
- R6: Two or more column lines low while one row is driven gives 11111.
- R7: Keys that answer in two different rows within one sweep give 11111. Once only one key remains, its code returns.
- R8: `key_code` changes only on the step edge that ends the 0111 row, which closes a sweep. At every other edge it holds its value.
- R9: The operator keys sit at row 2 columns 2 and 3 (codes 10 add and 11 subtract) and at row 3 columns 0 and 1 (codes 12 multiply and 13 equals).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high |
| col_n | input | COLS (4) | Column return lines, active low, asynchronous |
| row_n | output | ROWS (4) | Row drive, one line low at a time |
| key_code | output | CODE_W (5) | Registered key code, 11111 when idle or ambiguous |

## Verification
Once reset or clear is released, the step edges fall on rising edges STEP_DIV, 2·STEP_DIV and so on. `key_code` changes only on the first step edge and then on every fourth step edge after it (edges STEP_DIV, 5·STEP_DIV, ...). With STEP_DIV = 4, a key that is steady from release onward therefore appears 20 edges later. The bench samples 1 ns after edge 19 to see the old value and after edge 20 to see the new one. Row steps are checked in the same way, just before and just after edges 4, 8, 12 and 16. For stimulus that starts in the middle of a sweep, the checks wait 36 edges. That covers a partial sweep, one whole sweep of 16 edges, the publishing edge and the two synchronizer cycles, so the sampled code can only be the one the requirement predicts.

// File: rtl/keypad_pkg.sv
// Package: default geometry and timing for the keypad scanner.
// Assumes a square-ish matrix of at least 2 rows; the code is one bit wider
// than needed for the key count so that all ones stays free as the idle code.
package keypad_pkg;
    localparam int KP_ROWS     = 4;
    localparam int KP_COLS     = 4;
    localparam int KP_STEP_DIV = 8467;  // ~4 kHz steps from 33.8688 MHz
endpackage

// File: rtl/kp_step_tick.sv
// Module: step enable generator.
// Gives a one-cycle pulse every DIV system clocks. Reset and clear restart
// the count so the first pulse lands DIV cycles after release.
// Assumes DIV >= 4 so rows settle through the column synchronizer.
module kp_step_tick #(
    parameter int DIV = keypad_pkg::KP_STEP_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Count system clocks up to DIV-1, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> !tick);  // R1
endmodule

// File: rtl/kp_row_walker.sv
// Module: row drive sequencer.
// A small counter steps once per tick. Count k drives row (k-1) mod ROWS low,
// so the count 0 after reset drives the last row. The sweep ends on the tick
// taken while count is 0, i.e. when the last row's phase closes.
module kp_row_walker #(
    parameter int ROWS = keypad_pkg::KP_ROWS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick,
    output logic [ROWS-1:0] row_n,
    output logic            sweep_end
);
    localparam int RCW = $clog2(ROWS);

    logic [RCW-1:0] cnt;
    logic [RCW-1:0] idx;

    // Advance the row counter on each step, wrapping after ROWS-1.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= (cnt == RCW'(ROWS - 1)) ? '0 : cnt + 1'b1;
    end

    // Decode the count into a single low row line.
    always_comb begin
        idx   = (cnt == '0) ? RCW'(ROWS - 1) : cnt - 1'b1;
        row_n = ~(ROWS'(1) << idx);
    end

    assign sweep_end = tick && (cnt == '0);

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> !$stable(row_n));  // R1
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(row_n));  // R1
    AST_CLR_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (row_n == ~(ROWS'(1) << (ROWS - 1))));  // R2
endmodule

// File: rtl/kp_col_sync.sv
// Module: two-flop synchronizer for the asynchronous column lines.
// Resets to all ones (no column pulled low).
module kp_col_sync #(
    parameter int COLS = keypad_pkg::KP_COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_n,
    output logic [COLS-1:0] col_s
);
    logic [COLS-1:0] meta;

    // Move column lines through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta  <= '1;
            col_s <= '1;
        end else begin
            meta  <= col_n;
            col_s <= meta;
        end
    end
endmodule

// File: rtl/kp_encoder.sv
// Module: pattern-to-code encoder with per-sweep arbitration.
// On each step it joins {row_n, col_s} into one pattern and looks it up.
// Hits are gathered over a sweep; one clean hit is published at sweep end,
// anything else publishes the all-ones idle code.
module kp_encoder #(
    parameter int ROWS   = keypad_pkg::KP_ROWS,
    parameter int COLS   = keypad_pkg::KP_COLS,
    parameter int CODE_W = $clog2(ROWS * COLS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              sweep_end,
    input  logic [ROWS-1:0]   row_n,
    input  logic [COLS-1:0]   col_s,
    output logic [CODE_W-1:0] key_code
);
    localparam logic [CODE_W-1:0] IDLE = '1;

    // Look up the code for a joined row/column pattern; IDLE if unmatched.
    function automatic logic [CODE_W-1:0] map_pattern(
        input logic [ROWS+COLS-1:0] pat);
        logic [CODE_W-1:0] res;
        res = IDLE;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (pat == {~(ROWS'(1) << r), ~(COLS'(1) << c)})
                    res = CODE_W'(r * COLS + c);
            end
        end
        return res;
    endfunction

    logic [CODE_W-1:0] row_code, cand, cand_nx;
    logic              row_hit, row_multi;
    logic              seen, multi, seen_nx, multi_nx;

    // Combine this row's result with what the sweep has seen so far.
    always_comb begin
        row_code  = map_pattern({row_n, col_s});
        row_hit   = (row_code != IDLE);
        row_multi = ($countones(~col_s) > 1);
        seen_nx   = seen | row_hit;
        multi_nx  = multi | row_multi | (seen & row_hit);
        cand_nx   = row_hit ? row_code : cand;
    end

    // Track sweep state on each step and publish at sweep end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen     <= 1'b0;
            multi    <= 1'b0;
            cand     <= IDLE;
            key_code <= IDLE;
        end else if (tick) begin
            if (sweep_end) begin
                key_code <= (seen_nx && !multi_nx) ? cand_nx : IDLE;
                seen     <= 1'b0;
                multi    <= 1'b0;
                cand     <= IDLE;
            end else begin
                seen  <= seen_nx;
                multi <= multi_nx;
                cand  <= cand_nx;
            end
        end
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sweep_end && !clr) |=> $stable(key_code));  // R8
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (key_code == IDLE));  // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (key_code == IDLE) || (key_code < CODE_W'(ROWS * COLS)));  // R4
endmodule

// File: rtl/keypad_scanner.sv
// Module: keypad scanner top.
// Connects the step enable, row sequencer, column synchronizer and encoder.
// Assumes STEP_DIV >= 4 and ROWS >= 2; column lines may be asynchronous.
module keypad_scanner #(
    parameter int ROWS     = keypad_pkg::KP_ROWS,
    parameter int COLS     = keypad_pkg::KP_COLS,
    parameter int STEP_DIV = keypad_pkg::KP_STEP_DIV,
    parameter int CODE_W   = $clog2(ROWS * COLS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [COLS-1:0]   col_n,
    output logic [ROWS-1:0]   row_n,
    output logic [CODE_W-1:0] key_code
);
    logic            tick;
    logic            sweep_end;
    logic [COLS-1:0] col_s;

    kp_step_tick #(.DIV(STEP_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick)
    );

    kp_row_walker #(.ROWS(ROWS)) u_rows (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .row_n(row_n), .sweep_end(sweep_end)
    );

    kp_col_sync #(.COLS(COLS)) u_sync (
        .clk(clk), .rst_n(rst_n), .col_n(col_n), .col_s(col_s)
    );

    kp_encoder #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .sweep_end(sweep_end), .row_n(row_n), .col_s(col_s),
        .key_code(key_code)
    );
endmodule

// File: tb/keypad_scanner_bench.sv
`timescale 1ns/1ps
module keypad_scanner_bench;
    localparam int DIV  = 4;
    localparam int IDLE = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] col_n;
    logic [3:0] row_n;
    logic [4:0] key_code;
    logic [15:0] pressed = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    keypad_scanner #(.STEP_DIV(DIV)) u_keypad_scanner (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .col_n(col_n), .row_n(row_n), .key_code(key_code)
    );

    // Key matrix model: a pressed key shorts its column to its driven row.
    always_comb begin
        col_n = 4'b1111;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (pressed[r*4+c] && !row_n[r]) col_n[c] = 1'b0;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        pressed = '0;
        do_reset();
        check("R3 row after reset", int'(row_n), 4'b0111);
        check("R3 code after reset", int'(key_code), IDLE);
    endtask

    task automatic t_row_walk();
        pressed = '0;
        do_reset();
        edges(DIV - 1); check("R1 row before first step", int'(row_n), 4'b0111);
        edges(1);       check("R1 row step 1", int'(row_n), 4'b1110);
        edges(DIV);     check("R1 row step 2", int'(row_n), 4'b1101);
        edges(DIV);     check("R1 row step 3", int'(row_n), 4'b1011);
        edges(DIV);     check("R1 row wrap", int'(row_n), 4'b0111);
    endtask

    task automatic t_sweep_timing();
        do_reset();
        pressed = 16'h0001 << 5;
        edges(5*DIV - 1); check("R8 code before sweep end", int'(key_code), IDLE);
        edges(1);         check("R8 code at sweep end", int'(key_code), 5);
        edges(4*DIV - 1); check("R8 code held in sweep", int'(key_code), 5);
        pressed = '0;
    endtask

    task automatic t_all_keys();
        for (int k = 0; k < 16; k++) begin
            pressed = 16'h0001 << k;
            edges(36);
            if (k >= 10 && k <= 13) check("R9 operator key code", int'(key_code), k);
            else                    check("R4 single key code", int'(key_code), k);
        end
        pressed = '0;
    endtask

    task automatic t_no_key();
        pressed = 16'h0001 << 3;
        edges(36);
        pressed = '0;
        edges(36);
        check("R5 idle after release", int'(key_code), IDLE);
    endtask

    task automatic t_multi_col();
        pressed = (16'h0001 << 4) | (16'h0001 << 6);
        edges(36);
        check("R6 two columns one row", int'(key_code), IDLE);
        pressed = 16'h000F;
        edges(36);
        check("R6 four columns one row", int'(key_code), IDLE);
        pressed = '0;
    endtask

    task automatic t_multi_row();
        pressed = (16'h0001 << 1) | (16'h0001 << 9);
        edges(36);
        check("R7 keys in two rows", int'(key_code), IDLE);
        pressed = 16'h0001 << 9;
        edges(36);
        check("R7 one key left", int'(key_code), 9);
        pressed = '0;
    endtask

    task automatic t_clear();
        pressed = 16'h0001 << 7;
        edges(36);
        check("R2 code before clear", int'(key_code), 7);
        @(negedge clk);
        clr = 1'b1;
        edges(1);
        clr = 1'b0;
        check("R2 row after clear", int'(row_n), 4'b0111);
        check("R2 code after clear", int'(key_code), IDLE);
        edges(5*DIV - 1); check("R2 code before first sweep end", int'(key_code), IDLE);
        edges(1);         check("R2 code after restart", int'(key_code), 7);
        pressed = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_row_walk();
        t_sweep_timing();
        t_all_keys();
        t_no_key();
        t_multi_col();
        t_multi_row();
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule